// File: doc/BRIEF.md
# Throttled Memory-to-Memory Transfer Engine

A single-channel copy engine that moves data from a source region to a destination region as a series of read/write pairs on a simple request/ready memory port. Software fills a small descriptor through a register port. The descriptor holds the source and destination addresses, the read and write access sizes, the number of bytes per inner loop, the number of inner loops, a bandwidth code and a descriptor-chain address. Software then starts the engine through a status register.

The engine limits how much of the memory bus it takes. A two-bit code makes it hold the bus idle for a fixed number of cycles after each accepted access. When the read and write sizes match, two idle windows are skipped in every inner loop: the one after the first read, and the one after the last write. When all inner loops are finished, the engine can fetch a new descriptor from a 32-byte aligned address. A bad descriptor raises a sticky configuration error, and the engine does nothing until software clears it.

Top module: `dma_thr_top`

## Requirements
- R1: After reset, every register reads zero, `mem_req` is low, and `busy`, `done` and `cfg_err` are low.
- R2: Bandwidth code 0 (CTRL[5:4]=00) and the unused code 1 (01) both issue accesses with no idle request cycle between them. CTRL reads back exactly as written, code 01 included.
- R3: Bandwidth code 2 (10) leaves exactly 4 cycles with `mem_req` low after each accepted access.
- R4: Bandwidth code 3 (11) leaves exactly 8 cycles with `mem_req` low after each accepted access.
- R5: When source and destination sizes are equal, no idle cycles follow the first read of each inner loop, and none follow the last write of each inner loop.
- R6: A request that is not yet accepted stays asserted, with address, direction and write data unchanged, until `mem_ready` is high. Random `mem_ready` stalls do not change the data moved.
- R7: Pair j reads S bytes at SRC+j*S and writes the low D bytes of that little-endian value at DST+j*D. S and D come from CTRL[1:0] and CTRL[3:2] (code 0=1, 1=2, 2=4 bytes). An inner loop holds NBYTES/D pairs.
- R8: The engine runs CITER inner loops back to back. It then sets `done` and clears `busy`, having made exactly 2*CITER*NBYTES/D accesses. Descriptor register writes while `busy` is high are ignored.
- R9: A start is a write to STAT (register 6) with bit 0 set. A start with CTRL[6]=1 and SGA[4:0]≠0, or with NBYTES or CITER zero, sets `cfg_err` and issues no access. Starts are ignored while `cfg_err` is set. Writing STAT with bit 2 set clears it.
- R10: With CTRL[6]=1, after the last inner loop the engine reads six 4-byte words at SGA+4*i, with no idle cycles between them. The words land in registers 0..5 (SRC, DST, CTRL, NBYTES, CITER, SGA), and then `done` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 SRC, 1 DST, 2 CTRL, 3 NBYTES, 4 CITER, 5 SGA, 6 STAT) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`; STAT reads {err, done, busy} in bits 2..0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address |
| mem_size | output | 2 | Access size code (0=1, 1=2, 2=4 bytes) |
| mem_wdata | output | 32 | Write data, little-endian in low bytes |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Accepts the current request |
| busy | output | 1 | Engine is running |
| done | output | 1 | Last transfer completed |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench logs every accepted access together with the number of request-low cycles before it. It goes after four kinds of corner case.

The first is the idle window around the first read and last write of each inner loop when sizes match. A design that ignored the size comparison, or applied the exemption to the wrong access, would show a 4- or 8-cycle gap where none is due, or none where one is.

The second is the move from one inner loop to the next. A design that failed to re-arm the first-read exemption would stall there.

The third is random `mem_ready` back-pressure. A design that advanced addresses or dropped the request early would corrupt the destination image.

The fourth is the misaligned chain address and the descriptor fetch. Here a faulty design would start anyway, would fail to hold the error, or would load the fetched words into the wrong registers.

// File: rtl/dma_thr_pkg.sv
package dma_thr_pkg;
    localparam int REG_W         = 32;
    localparam int REG_IX_W      = 3;
    localparam int NUM_DESC      = 6;
    localparam int SG_ALIGN_BITS = 5;
    localparam int STALL_LO      = 4;
    localparam int STALL_HI      = 8;
    localparam int STALL_W       = $clog2(STALL_HI + 1);

    localparam logic [REG_IX_W-1:0] IX_SRC    = 3'd0;
    localparam logic [REG_IX_W-1:0] IX_DST    = 3'd1;
    localparam logic [REG_IX_W-1:0] IX_CTRL   = 3'd2;
    localparam logic [REG_IX_W-1:0] IX_NBYTES = 3'd3;
    localparam logic [REG_IX_W-1:0] IX_CITER  = 3'd4;
    localparam logic [REG_IX_W-1:0] IX_SGA    = 3'd5;
    localparam logic [REG_IX_W-1:0] IX_STAT   = 3'd6;

    localparam int STAT_GO_BIT  = 0;
    localparam int STAT_CLR_BIT = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SG
    } eng_state_e;

    typedef struct packed {
        logic       sg_en;
        logic [1:0] bwc;
        logic [1:0] dsz;
        logic [1:0] ssz;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [STALL_W-1:0] stall_len(input logic [1:0] bwc);
        case (bwc)
            2'b10:   return STALL_W'(STALL_LO);
            2'b11:   return STALL_W'(STALL_HI);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/dma_thr_throttle.sv
module dma_thr_throttle
    import dma_thr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [STALL_W-1:0] load_val,
    output logic               busy
);
    logic [STALL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);

    // an access can only be accepted once the idle window has drained
    AST_NO_LOAD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
        busy |-> !load) else $error("stall counter reloaded while counting"); // R3
endmodule

// File: rtl/dma_thr_regs.sv
module dma_thr_regs
    import dma_thr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_we,
    input  logic [REG_IX_W-1:0] host_addr,
    input  logic [REG_W-1:0]    host_wdata,
    output logic [REG_W-1:0]    host_rdata,
    input  logic                ld_we,
    input  logic [REG_IX_W-1:0] ld_idx,
    input  logic [REG_W-1:0]    ld_data,
    input  logic                busy,
    input  logic                start_ok,
    input  logic                done_set,
    input  logic                err_set,
    output logic [REG_W-1:0]    d_src,
    output logic [REG_W-1:0]    d_dst,
    output logic [REG_W-1:0]    d_sga,
    output logic [CNT_W-1:0]    d_nbytes,
    output logic [CNT_W-1:0]    d_citer,
    output ctrl_t               d_ctrl,
    output logic                start_req,
    output logic                err_q,
    output logic                done_q
);
    logic [REG_W-1:0] desc_q [NUM_DESC];
    logic             stat_wr;

    assign stat_wr = host_we && (host_addr == IX_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_DESC; i++) desc_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_DESC; i++) begin
                if (ld_we) begin
                    if (ld_idx == REG_IX_W'(i)) desc_q[i] <= ld_data;
                end else if (host_we && !busy && host_addr == REG_IX_W'(i)) begin
                    desc_q[i] <= host_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (err_set) err_q <= 1'b1;
            else if (stat_wr && host_wdata[STAT_CLR_BIT]) err_q <= 1'b0;
            if (start_ok) done_q <= 1'b0;
            else if (done_set) done_q <= 1'b1;
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_DESC; i++) begin
            if (host_addr == REG_IX_W'(i)) host_rdata = desc_q[i];
        end
        if (host_addr == IX_STAT) host_rdata = {{(REG_W-3){1'b0}}, err_q, done_q, busy};
    end

    assign start_req = stat_wr && host_wdata[STAT_GO_BIT];
    assign d_src     = desc_q[IX_SRC];
    assign d_dst     = desc_q[IX_DST];
    assign d_sga     = desc_q[IX_SGA];
    assign d_nbytes  = desc_q[IX_NBYTES][CNT_W-1:0];
    assign d_citer   = desc_q[IX_CITER][CNT_W-1:0];
    assign d_ctrl    = ctrl_t'(desc_q[IX_CTRL][CTRL_W-1:0]);

    AST_ERR_KEEPS_IDLE: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !busy) else $error("engine running with error set"); // R9
    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy) else $error("done while running"); // R8
endmodule

// File: rtl/dma_thr_seq.sv
module dma_thr_seq
    import dma_thr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_req,
    input  logic                err_q,
    input  logic [ADDR_W-1:0]   d_src,
    input  logic [ADDR_W-1:0]   d_dst,
    input  logic [ADDR_W-1:0]   d_sga,
    input  logic [CNT_W-1:0]    d_nbytes,
    input  logic [CNT_W-1:0]    d_citer,
    input  ctrl_t               d_ctrl,
    input  logic                stall_busy,
    input  logic                mem_ready,
    input  logic [REG_W-1:0]    mem_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [1:0]          mem_size,
    output logic [REG_W-1:0]    mem_wdata,
    output logic                stall_load,
    output logic [STALL_W-1:0]  stall_val,
    output logic                busy,
    output logic                start_ok,
    output logic                done_set,
    output logic                err_set,
    output logic                ld_we,
    output logic [REG_IX_W-1:0] ld_idx,
    output logic [REG_W-1:0]    ld_data
);
    localparam logic [REG_IX_W-1:0] SG_LAST = REG_IX_W'(NUM_DESC - 1);

    eng_state_e            state_q;
    logic [ADDR_W-1:0]     src_q, dst_q, sga_q;
    logic [CNT_W-1:0]      left_q, iter_q, nb_q;
    logic                  first_q;
    ctrl_t                 ctrl_q;
    logic [REG_W-1:0]      hold_q;
    logic [REG_IX_W-1:0]   sg_idx_q;

    logic [2:0]            sbytes, dbytes;
    logic                  same_sz, last_wr, acc, cfg_ok, start_try, final_loop;
    logic [STALL_W-1:0]    gap_len;

    assign sbytes     = size_bytes(ctrl_q.ssz);
    assign dbytes     = size_bytes(ctrl_q.dsz);
    assign same_sz    = (sbytes == dbytes);
    assign last_wr    = (left_q <= CNT_W'(dbytes));
    assign final_loop = (iter_q == CNT_W'(1));
    assign gap_len    = stall_len(ctrl_q.bwc);

    assign cfg_ok    = (d_nbytes != '0) && (d_citer != '0) &&
                       !(d_ctrl.sg_en && d_sga[SG_ALIGN_BITS-1:0] != '0);
    assign start_try = (state_q == ST_IDLE) && start_req && !err_q;
    assign start_ok  = start_try && cfg_ok;
    assign err_set   = start_try && !cfg_ok;
    assign busy      = (state_q != ST_IDLE);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_size  = 2'd2;
        mem_wdata = hold_q;
        case (state_q)
            ST_RD: begin
                mem_req  = !stall_busy;
                mem_addr = src_q;
                mem_size = ctrl_q.ssz;
            end
            ST_WR: begin
                mem_req  = !stall_busy;
                mem_we   = 1'b1;
                mem_addr = dst_q;
                mem_size = ctrl_q.dsz;
            end
            ST_SG: begin
                mem_req  = !stall_busy;
                mem_addr = sga_q + ADDR_W'({sg_idx_q, 2'b00});
            end
            default: ;
        endcase
    end

    assign acc = mem_req && mem_ready;

    // idle window after each data access; equal sizes skip the inner-loop ends
    always_comb begin
        stall_load = acc && (state_q == ST_RD || state_q == ST_WR);
        stall_val  = gap_len;
        if (state_q == ST_RD && first_q && same_sz) stall_val = '0;
        if (state_q == ST_WR && last_wr && same_sz) stall_val = '0;
    end

    assign done_set = acc && ((state_q == ST_WR && last_wr && final_loop && !ctrl_q.sg_en) ||
                              (state_q == ST_SG && sg_idx_q == SG_LAST));
    assign ld_we    = acc && (state_q == ST_SG);
    assign ld_idx   = sg_idx_q;
    assign ld_data  = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            src_q    <= '0;
            dst_q    <= '0;
            sga_q    <= '0;
            left_q   <= '0;
            iter_q   <= '0;
            nb_q     <= '0;
            first_q  <= 1'b0;
            ctrl_q   <= '0;
            hold_q   <= '0;
            sg_idx_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_ok) begin
                    ctrl_q  <= d_ctrl;
                    nb_q    <= d_nbytes;
                    sga_q   <= d_sga;
                    src_q   <= d_src;
                    dst_q   <= d_dst;
                    left_q  <= d_nbytes;
                    iter_q  <= d_citer;
                    first_q <= 1'b1;
                    state_q <= ST_RD;
                end
                ST_RD: if (acc) begin
                    hold_q  <= mem_rdata;
                    src_q   <= src_q + ADDR_W'(sbytes);
                    first_q <= 1'b0;
                    state_q <= ST_WR;
                end
                ST_WR: if (acc) begin
                    dst_q <= dst_q + ADDR_W'(dbytes);
                    if (last_wr) begin
                        if (final_loop) begin
                            sg_idx_q <= '0;
                            state_q  <= ctrl_q.sg_en ? ST_SG : ST_IDLE;
                        end else begin
                            iter_q  <= iter_q - 1'b1;
                            left_q  <= nb_q;
                            first_q <= 1'b1;
                            state_q <= ST_RD;
                        end
                    end else begin
                        left_q  <= left_q - CNT_W'(dbytes);
                        state_q <= ST_RD;
                    end
                end
                ST_SG: if (acc) begin
                    if (sg_idx_q == SG_LAST) state_q <= ST_IDLE;
                    else sg_idx_q <= sg_idx_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
        else $error("request withdrawn or changed before acceptance"); // R6
    AST_CHAIN_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SG) |-> (sga_q[SG_ALIGN_BITS-1:0] == '0))
        else $error("descriptor fetch from misaligned address"); // R10
endmodule

// File: rtl/dma_thr_top.sv
module dma_thr_top
    import dma_thr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ready,
    output logic              busy,
    output logic              done,
    output logic              cfg_err
);
    logic [REG_W-1:0]    d_src, d_dst, d_sga, ld_data;
    logic [CNT_W-1:0]    d_nbytes, d_citer;
    ctrl_t               d_ctrl;
    logic                start_req, start_ok, done_set, err_set, ld_we;
    logic [REG_IX_W-1:0] ld_idx;
    logic                stall_load, stall_busy;
    logic [STALL_W-1:0]  stall_val;

    dma_thr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .host_we(reg_we), .host_addr(reg_addr), .host_wdata(reg_wdata), .host_rdata(reg_rdata),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .busy(busy), .start_ok(start_ok), .done_set(done_set), .err_set(err_set),
        .d_src(d_src), .d_dst(d_dst), .d_sga(d_sga), .d_nbytes(d_nbytes), .d_citer(d_citer),
        .d_ctrl(d_ctrl), .start_req(start_req), .err_q(cfg_err), .done_q(done)
    );

    dma_thr_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .start_req(start_req), .err_q(cfg_err),
        .d_src(d_src[ADDR_W-1:0]), .d_dst(d_dst[ADDR_W-1:0]), .d_sga(d_sga[ADDR_W-1:0]),
        .d_nbytes(d_nbytes), .d_citer(d_citer), .d_ctrl(d_ctrl),
        .stall_busy(stall_busy), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .stall_load(stall_load), .stall_val(stall_val),
        .busy(busy), .start_ok(start_ok), .done_set(done_set), .err_set(err_set),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data)
    );

    dma_thr_throttle u_thr (
        .clk(clk), .rst(rst), .load(stall_load), .load_val(stall_val), .busy(stall_busy)
    );
endmodule

// File: tb/dma_thr_top_tb_top.sv
module dma_thr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        busy, done, cfg_err;

    always #2 clk = ~clk;

    dma_thr_top dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .busy(busy), .done(done), .cfg_err(cfg_err)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [7:0]  mem [256];
    logic [7:0]  init_mem [256];
    int          acc_n = 0;
    int          idle_run = 0;
    bit          rand_rdy = 0;
    int          log_gap [64];
    bit          log_we [64];
    logic [31:0] log_addr [64];

    function automatic int sz_bytes(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic int gap_of(input int bw);
        return (bw == 2) ? 4 : (bw == 3) ? 8 : 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // memory model: decides ready, returns data and logs accesses at the falling edge
    always @(negedge clk) begin
        logic        rdy;
        logic [31:0] rv;
        rdy = rand_rdy ? ($urandom % 3 != 0) : 1'b1;
        rv  = '0;
        for (int b = 0; b < 4; b++)
            if (b < sz_bytes(int'(mem_size))) rv[8*b +: 8] = mem[8'(mem_addr + 32'(b))];
        mem_ready = rdy;
        mem_rdata = rv;
        if (!rst && mem_req && rdy) begin
            if (acc_n < 64) begin
                log_gap[acc_n]  = idle_run;
                log_we[acc_n]   = mem_we;
                log_addr[acc_n] = mem_addr;
            end
            acc_n++;
            idle_run = 0;
            if (mem_we)
                for (int b = 0; b < sz_bytes(int'(mem_size)); b++)
                    mem[8'(mem_addr + 32'(b))] = mem_wdata[8*b +: 8];
        end else if (!mem_req) begin
            idle_run++;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic run_xfer(input int ss, input int ds, input int bw, input int k,
                            input int ci, input bit rr, input bit sg, input bit poke);
        int          sb, db, n, pairs, bad, first_bad;
        bit          eq;
        logic [31:0] ctrl, v, val;
        logic [7:0]  expm [256];
        string       tg;
        sb = sz_bytes(ss); db = sz_bytes(ds); n = gap_of(bw);
        eq = (sb == db); pairs = k * ci;
        ctrl = {25'd0, sg, 2'(bw), 2'(ds), 2'(ss)};
        for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
        for (int i = 128; i < 192; i++) mem[i] = 8'h00;
        for (int i = 0; i < 256; i++) init_mem[i] = mem[i];
        reg_write(3'd0, 32'h0);
        reg_write(3'd1, 32'h80);
        reg_write(3'd2, ctrl);
        reg_write(3'd3, 32'(k * db));
        reg_write(3'd4, 32'(ci));
        reg_write(3'd5, sg ? 32'hC0 : 32'h0);
        reg_read(3'd2, v);
        chk(v == ctrl, "R2", "CTRL readback", v, ctrl);
        acc_n = 0; idle_run = 0; rand_rdy = rr;
        reg_write(3'd6, 32'h1);
        if (poke) reg_write(3'd0, 32'h55);
        while (!done) @(negedge clk);
        rand_rdy = 0;
        chk(acc_n == 2 * pairs + (sg ? 6 : 0), "R8", "access count", acc_n, 2 * pairs + (sg ? 6 : 0));
        chk(done && !busy, "R8", "done/busy at end", {done, busy}, 2'b10);
        for (int i = 0; i < 2 * pairs; i++) begin
            int j;
            logic [31:0] ea;
            j  = i / 2;
            ea = (i % 2) ? 32'(128 + j * db) : 32'(j * sb);
            chk(log_we[i] == (i % 2) && log_addr[i] == ea, rr ? "R6" : "R7", "access address",
                log_addr[i], ea);
            if (i > 0) begin
                int  p, pm, eg;
                bit  ex;
                p  = i - 1;
                pm = (p / 2) % k;
                ex = eq && (((p % 2) == 0 && pm == 0) || ((p % 2) == 1 && pm == k - 1));
                eg = ex ? 0 : n;
                tg = ex ? "R5" : (bw == 2) ? "R3" : (bw == 3) ? "R4" : "R2";
                chk(log_gap[i] == eg, tg, "idle gap", log_gap[i], eg);
            end
        end
        for (int i = 0; i < 256; i++) expm[i] = init_mem[i];
        for (int j = 0; j < pairs; j++) begin
            val = '0;
            for (int b = 0; b < sb; b++) val[8*b +: 8] = init_mem[j * sb + b];
            for (int b = 0; b < db; b++) expm[128 + j * db + b] = val[8*b +: 8];
        end
        bad = 0; first_bad = 0;
        for (int i = 128; i < 192; i++)
            if (mem[i] !== expm[i]) begin
                if (bad == 0) first_bad = i;
                bad++;
            end
        chk(bad == 0, rr ? "R6" : "R7", "destination bytes", mem[first_bad], expm[first_bad]);
        if (poke) begin
            reg_read(3'd0, v);
            chk(v == 32'h0, "R8", "SRC write while busy ignored", v, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] w [6];
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            reg_read(3'(a), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(!mem_req && !busy && !done && !cfg_err, "R1", "outputs after reset",
            {mem_req, busy, done, cfg_err}, 0);

        run_xfer(2, 2, 3, 3, 2, 0, 0, 0);   // R4 with R5 exemptions
        run_xfer(0, 0, 2, 4, 1, 0, 0, 0);   // R3 with R5 exemptions
        run_xfer(0, 2, 2, 2, 2, 1, 0, 0);   // unequal sizes, random ready
        run_xfer(1, 1, 1, 3, 1, 0, 0, 0);   // reserved code behaves as no stall
        run_xfer(1, 2, 3, 2, 1, 0, 0, 1);   // writes while busy ignored

        // R10 descriptor chain fetch
        for (int i = 0; i < 6; i++) w[i] = $urandom;
        w[5] = 32'h40;
        for (int i = 0; i < 6; i++)
            for (int b = 0; b < 4; b++) mem[192 + 4 * i + b] = w[i][8*b +: 8];
        run_xfer(0, 1, 3, 2, 1, 0, 1, 0);
        for (int i = 0; i < 6; i++) begin
            chk(log_addr[4 + i] == 32'(192 + 4 * i) && !log_we[4 + i], "R10", "chain fetch address",
                log_addr[4 + i], 192 + 4 * i);
            if (i > 0) chk(log_gap[4 + i] == 0, "R10", "chain fetch gap", log_gap[4 + i], 0);
            reg_read(3'(i), v);
            chk(v == w[i], "R10", "reloaded register", v, w[i]);
        end

        // R9 configuration errors
        reg_write(3'd2, 32'h40);
        reg_write(3'd3, 32'h4);
        reg_write(3'd4, 32'h1);
        reg_write(3'd5, 32'hC4);
        acc_n = 0;
        reg_write(3'd6, 32'h1);
        repeat (5) @(negedge clk);
        chk(cfg_err && !busy && acc_n == 0, "R9", "misaligned chain start", {cfg_err, busy, acc_n != 0}, 3'b100);
        reg_write(3'd5, 32'hC0);
        reg_write(3'd6, 32'h1);
        repeat (5) @(negedge clk);
        chk(!busy && acc_n == 0, "R9", "start ignored while error set", acc_n, 0);
        reg_read(3'd6, v);
        chk(v[2] == 1'b1, "R9", "STAT error bit", v, 4);
        reg_write(3'd6, 32'h4);
        chk(!cfg_err, "R9", "error cleared", cfg_err, 0);
        reg_write(3'd2, 32'h0);
        reg_write(3'd3, 32'h0);
        reg_write(3'd6, 32'h1);
        repeat (3) @(negedge clk);
        chk(cfg_err && acc_n == 0, "R9", "zero minor count", cfg_err, 1);
        reg_write(3'd6, 32'h4);

        // random mix
        for (int r = 0; r < 20; r++)
            run_xfer($urandom % 3, $urandom % 3, $urandom % 4, 1 + $urandom % 4,
                     1 + $urandom % 2, r % 2, 0, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule